// File: doc/BRIEF.md
# AUX Channel Transaction Sequencer

This block carries out one request on a display auxiliary channel by driving a low-level transceiver through a fixed control sequence. A requester hands over a 4-bit command, a 20-bit address, a byte count of 1 to 16 and up to 16 bytes of write payload through a valid/ready handshake.

The sequencer then works through these steps:
- It claims the channel and confirms that the claim was granted.
- It polls the transceiver for readiness a bounded number of times.
- For a write command, it loads the outgoing payload.
- It runs the request. Each attempt is a reset pulse, a quiet cycle, and a start flag held until the transceiver reports completion.
- After a settling delay it samples the reply, and it runs the request again for as long as the sink answers with a native deferral.
- It gives the channel back and confirms that the grant has been withdrawn.
- It waits a final delay.

The result arrives as a single-cycle done pulse that carries a status class, the reply field and any read data.

Every delay is a parameter counted in clock cycles. The polling and retry limits are parameters too, so the same block fits both fast and slow transceivers. The electrical signalling, the line coding and the sink's behaviour lie outside this block.

Top module: `auxreq_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `done_pulse` is high for exactly one cycle per request.
- R2: After claiming the channel (`lnk_acq` high), the block samples `lnk_grant` following GRANT_WAIT. If the grant is absent, the request ends with status 1 (I/O error) and no attempt (`lnk_rst` pulse) is made.
- R3: `lnk_ready` is sampled up to POLL_TRIES times, POLL_GAP cycles apart. If it is never high, the request ends with status 2 (busy) and no attempt is made.
- R4: Bit 0 of the command selects the direction: 1 is a read and 0 is a write. A write pulses `lnk_wload` once before the first attempt. A read never pulses it. `lnk_len` carries the byte count minus one. On `lnk_wdata`, the bytes above the count are zero, with byte k at bits 8k+7:8k.
- R5: Every attempt raises `lnk_rst` for one cycle, leaves one cycle with neither `lnk_rst` nor `lnk_start`, and then holds `lnk_start` until `lnk_done` is seen. `lnk_rst` and `lnk_start` are never high together.
- R6: If `lnk_done` does not arrive within CLR_TMO cycles of raising `lnk_start`, the request ends with status 2 (busy).
- R7: When `lnk_reply[1:0]` equals 2'b10 (native deferral), the block makes another attempt. On the MAX_ATTEMPTS-th deferral it ends with status 3 (remote error) after exactly MAX_ATTEMPTS attempts.
- R8: For a read, a `lnk_rcount` that differs from the requested byte count gives status 3. Otherwise `done_rdata` holds the received bytes, with the bytes above the count forced to zero.
- R9: Before finishing, the block always drops `lnk_acq` and samples `lnk_grant` after GRANT_WAIT. A grant still present gives status 1, which overrides any earlier outcome.
- R10: A request that passes every check ends with status 0 and reports the 4-bit reply in `done_reply`, and any non-deferral native reply (including a refusal) counts as passing. On any error `done_reply` is zero. `done_pulse` comes no sooner than GRANT_WAIT+TAIL_CYC cycles after `lnk_acq` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_cmd | input | 4 | Command; bit 0 set means read |
| req_addr | input | 20 | Target address |
| req_len | input | 4 | Byte count minus one |
| req_wdata | input | 128 | Write payload, byte k at bits 8k+7:8k |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_code | output | 2 | 0 ok, 1 I/O error, 2 busy, 3 remote error |
| done_reply | output | 4 | Reply field on success, else zero |
| done_rdata | output | 128 | Read payload, bytes above the count zero |
| lnk_acq | output | 1 | Channel claim request |
| lnk_grant | input | 1 | Channel claim granted |
| lnk_ready | input | 1 | Transceiver ready status |
| lnk_wload | output | 1 | Load outgoing payload strobe |
| lnk_wdata | output | 128 | Outgoing payload (four 32-bit words) |
| lnk_cmd | output | 4 | Command to the transceiver |
| lnk_addr | output | 20 | Address to the transceiver |
| lnk_len | output | 4 | Byte count minus one |
| lnk_rst | output | 1 | Per-attempt reset pulse |
| lnk_start | output | 1 | Start flag, held until done |
| lnk_done | input | 1 | Start flag has self-cleared |
| lnk_reply | input | 4 | Reply status; bits 1:0 native field |
| lnk_rcount | input | 5 | Bytes received |
| lnk_rdata | input | 128 | Incoming payload (four 32-bit words) |

## Verification
The main sequence is exercised with writes, with full-length and short reads, and with reads whose received count does not match, so that the payload load strobe, the length encoding and the byte masking are each checked in both directions. Reply patterns run from an immediate acknowledgement, through a refusal and a few deferrals, to endless deferral, and this separates a retry from a reported reply and an exhausted retry budget. Faults are placed one at a time in the claim, the ready poll, the start completion and the release, and the status class and the attempt count together show which stage ended the request.

// File: rtl/auxseq_pkg.sv
package auxseq_pkg;
   typedef enum logic [1:0] {
      ST_OK     = 2'd0,
      ST_IOERR  = 2'd1,
      ST_BUSY   = 2'd2,
      ST_REMOTE = 2'd3
   } aux_status_e;

   localparam logic [1:0] NATIVE_DEFER = 2'b10;

   typedef enum logic [3:0] {
      S_IDLE, S_ACQ, S_POLL, S_GAP, S_LOAD, S_RST, S_QUIET,
      S_START, S_SETTLE, S_EVAL, S_REL, S_TAIL, S_DONE
   } seq_state_e;
endpackage

// File: rtl/auxseq_timer.sv
module auxseq_timer #(
   parameter int TMR_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             zero
);
   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/auxseq_tally.sv
module auxseq_tally #(
   parameter int LIMIT = 16,
   localparam int W = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("auxseq_tally: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + 1'b1;
   end

   a_r7_tally_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= W'(LIMIT));
endmodule

// File: rtl/auxseq_bytemask.sv
module auxseq_bytemask #(
   parameter int NBYTES = 16,
   localparam int LEN_W = $clog2(NBYTES)
) (
   input  logic [8*NBYTES-1:0] din,
   input  logic [LEN_W-1:0]    last,
   output logic [8*NBYTES-1:0] dout
);
   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         localparam logic [LEN_W:0] IDX = (LEN_W+1)'(b);
         assign dout[8*b +: 8] = (IDX <= {1'b0, last}) ? din[8*b +: 8] : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/auxreq_seq.sv
module auxreq_seq
   import auxseq_pkg::*;
#(
   parameter int CMD_W        = 4,
   parameter int ADDR_W       = 20,
   parameter int NBYTES       = 16,
   parameter int REPLY_W      = 4,
   parameter int TMR_W        = 17,
   parameter int GRANT_WAIT   = 2,
   parameter int POLL_TRIES   = 3,
   parameter int POLL_GAP     = 12500,
   parameter int CLR_TMO      = 1000,
   parameter int SETTLE_CYC   = 50000,
   parameter int TAIL_CYC     = 50000,
   parameter int MAX_ATTEMPTS = 16,
   localparam int DATA_W = 8 * NBYTES,
   localparam int LEN_W  = $clog2(NBYTES),
   localparam int CNT_W  = LEN_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [CMD_W-1:0]   req_cmd,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [LEN_W-1:0]   req_len,
   input  logic [DATA_W-1:0]  req_wdata,
   output logic               done_pulse,
   output logic [1:0]         done_code,
   output logic [REPLY_W-1:0] done_reply,
   output logic [DATA_W-1:0]  done_rdata,
   output logic               lnk_acq,
   input  logic               lnk_grant,
   input  logic               lnk_ready,
   output logic               lnk_wload,
   output logic [DATA_W-1:0]  lnk_wdata,
   output logic [CMD_W-1:0]   lnk_cmd,
   output logic [ADDR_W-1:0]  lnk_addr,
   output logic [LEN_W-1:0]   lnk_len,
   output logic               lnk_rst,
   output logic               lnk_start,
   input  logic               lnk_done,
   input  logic [REPLY_W-1:0] lnk_reply,
   input  logic [CNT_W-1:0]   lnk_rcount,
   input  logic [DATA_W-1:0]  lnk_rdata
);
   localparam int POLL_W = $clog2(POLL_TRIES + 1);
   localparam int ATT_W  = $clog2(MAX_ATTEMPTS + 1);

   generate
      if (NBYTES < 2 || (1 << LEN_W) != NBYTES) begin : g_bad_nbytes
         $error("auxreq_seq: NBYTES must be a power of two of at least 2");
      end
      if (REPLY_W < 2) begin : g_bad_reply
         $error("auxreq_seq: REPLY_W must hold the native field");
      end
      if (POLL_TRIES < 1 || MAX_ATTEMPTS < 1) begin : g_bad_limits
         $error("auxreq_seq: poll and attempt limits must be positive");
      end
      if (GRANT_WAIT >= (1 << TMR_W) || POLL_GAP >= (1 << TMR_W) ||
          CLR_TMO >= (1 << TMR_W) || SETTLE_CYC >= (1 << TMR_W) ||
          TAIL_CYC >= (1 << TMR_W)) begin : g_bad_tmr
         $error("auxreq_seq: a delay does not fit TMR_W");
      end
   endgenerate

   seq_state_e         st, nxt;
   logic [CMD_W-1:0]   cmd_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LEN_W-1:0]   len_q;
   logic [DATA_W-1:0]  wdata_q;
   aux_status_e        code_q;
   logic [REPLY_W-1:0] reply_q;
   logic [DATA_W-1:0]  rdata_q;
   logic [DATA_W-1:0]  rdata_m;

   logic               tmr_ld, tmr_zero;
   logic [TMR_W-1:0]   tmr_val;
   logic               poll_clr, poll_inc, att_clr, att_inc;
   logic [POLL_W-1:0]  poll_cnt;
   logic [ATT_W-1:0]   att_cnt;
   logic               accept, set_err, ok_cap;
   aux_status_e        err_val;
   logic               is_read;
   logic [CNT_W-1:0]   want_cnt;

   assign is_read  = cmd_q[0];
   assign want_cnt = {1'b0, len_q} + 1'b1;
   assign accept   = (st == S_IDLE) && req_valid;

   auxseq_timer #(.TMR_W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .zero(tmr_zero)
   );

   auxseq_tally #(.LIMIT(POLL_TRIES)) u_polls (
      .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .count(poll_cnt)
   );

   auxseq_tally #(.LIMIT(MAX_ATTEMPTS)) u_attempts (
      .clk(clk), .rst_n(rst_n), .clr(att_clr), .inc(att_inc), .count(att_cnt)
   );

   auxseq_bytemask #(.NBYTES(NBYTES)) u_wmask (
      .din(wdata_q), .last(len_q), .dout(lnk_wdata)
   );

   auxseq_bytemask #(.NBYTES(NBYTES)) u_rmask (
      .din(lnk_rdata), .last(len_q), .dout(rdata_m)
   );

   always_comb begin
      nxt      = st;
      tmr_ld   = 1'b0;
      tmr_val  = '0;
      poll_clr = 1'b0;
      poll_inc = 1'b0;
      att_clr  = 1'b0;
      att_inc  = 1'b0;
      set_err  = 1'b0;
      err_val  = ST_OK;
      ok_cap   = 1'b0;
      case (st)
         S_IDLE: if (req_valid) begin
            nxt = S_ACQ; tmr_ld = 1'b1; tmr_val = TMR_W'(GRANT_WAIT);
            att_clr = 1'b1; poll_clr = 1'b1;
         end
         S_ACQ: if (tmr_zero) begin
            if (!lnk_grant) begin
               set_err = 1'b1; err_val = ST_IOERR;
               nxt = S_REL; tmr_ld = 1'b1; tmr_val = TMR_W'(GRANT_WAIT);
            end else nxt = S_POLL;
         end
         S_POLL: begin
            if (lnk_ready) nxt = is_read ? S_RST : S_LOAD;
            else if (poll_cnt == POLL_W'(POLL_TRIES - 1)) begin
               set_err = 1'b1; err_val = ST_BUSY;
               nxt = S_REL; tmr_ld = 1'b1; tmr_val = TMR_W'(GRANT_WAIT);
            end else begin
               poll_inc = 1'b1;
               nxt = S_GAP; tmr_ld = 1'b1; tmr_val = TMR_W'(POLL_GAP);
            end
         end
         S_GAP:   if (tmr_zero) nxt = S_POLL;
         S_LOAD:  nxt = S_RST;
         S_RST:   nxt = S_QUIET;
         S_QUIET: begin
            nxt = S_START; tmr_ld = 1'b1; tmr_val = TMR_W'(CLR_TMO);
         end
         S_START: begin
            if (lnk_done) begin
               nxt = S_SETTLE; tmr_ld = 1'b1; tmr_val = TMR_W'(SETTLE_CYC);
            end else if (tmr_zero) begin
               set_err = 1'b1; err_val = ST_BUSY;
               nxt = S_REL; tmr_ld = 1'b1; tmr_val = TMR_W'(GRANT_WAIT);
            end
         end
         S_SETTLE: if (tmr_zero) nxt = S_EVAL;
         S_EVAL: begin
            if (lnk_reply[1:0] == NATIVE_DEFER) begin
               att_inc = 1'b1;
               if (att_cnt == ATT_W'(MAX_ATTEMPTS - 1)) begin
                  set_err = 1'b1; err_val = ST_REMOTE;
                  nxt = S_REL; tmr_ld = 1'b1; tmr_val = TMR_W'(GRANT_WAIT);
               end else nxt = S_RST;
            end else begin
               if (is_read && lnk_rcount != want_cnt) begin
                  set_err = 1'b1; err_val = ST_REMOTE;
               end else ok_cap = 1'b1;
               nxt = S_REL; tmr_ld = 1'b1; tmr_val = TMR_W'(GRANT_WAIT);
            end
         end
         S_REL: if (tmr_zero) begin
            if (lnk_grant) begin
               set_err = 1'b1; err_val = ST_IOERR;
            end
            nxt = S_TAIL; tmr_ld = 1'b1; tmr_val = TMR_W'(TAIL_CYC);
         end
         S_TAIL:  if (tmr_zero) nxt = S_DONE;
         S_DONE:  nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cmd_q   <= '0;
         addr_q  <= '0;
         len_q   <= '0;
         wdata_q <= '0;
         code_q  <= ST_OK;
         reply_q <= '0;
         rdata_q <= '0;
      end else begin
         st <= nxt;
         if (accept) begin
            cmd_q   <= req_cmd;
            addr_q  <= req_addr;
            len_q   <= req_len;
            wdata_q <= req_wdata;
            code_q  <= ST_OK;
            reply_q <= '0;
            rdata_q <= '0;
         end else if (set_err) begin
            code_q  <= err_val;
            reply_q <= '0;
         end else if (ok_cap) begin
            reply_q <= lnk_reply;
            if (is_read) rdata_q <= rdata_m;
         end
      end
   end

   assign req_ready  = (st == S_IDLE);
   assign done_pulse = (st == S_DONE);
   assign done_code  = code_q;
   assign done_reply = reply_q;
   assign done_rdata = rdata_q;
   assign lnk_acq    = (st != S_IDLE) && (st != S_REL) && (st != S_TAIL) && (st != S_DONE);
   assign lnk_wload  = (st == S_LOAD);
   assign lnk_rst    = (st == S_RST);
   assign lnk_start  = (st == S_START);
   assign lnk_cmd    = cmd_q;
   assign lnk_addr   = addr_q;
   assign lnk_len    = len_q;

   a_r5_rst_start_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(lnk_rst && lnk_start));
   a_r5_quiet_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_rst |=> !lnk_rst && !lnk_start);
   a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !lnk_acq && !lnk_start && !done_pulse);
   a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);
   a_r9_done_released: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> !lnk_acq);
   a_r6_start_claimed: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_start |-> lnk_acq);
   a_r4_wload_claimed: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_wload |-> lnk_acq && !lnk_cmd[0]);
   a_r4_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_acq && $past(lnk_acq)) |-> $stable(lnk_len));
   a_r10_reply_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse && done_code != 2'd0) |-> done_reply == '0);
endmodule

// File: tb/test_auxreq_seq.sv
module test_auxreq_seq;
   localparam int GW = 2, PG = 4, CT = 8, SC = 6, TC = 5, MA = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [3:0]   req_cmd = '0;
   logic [19:0]  req_addr = '0;
   logic [3:0]   req_len = '0;
   logic [127:0] req_wdata = '0;
   logic         done_pulse;
   logic [1:0]   done_code;
   logic [3:0]   done_reply;
   logic [127:0] done_rdata;
   logic         lnk_acq, lnk_wload, lnk_rst, lnk_start;
   logic [127:0] lnk_wdata;
   logic [3:0]   lnk_cmd, lnk_len;
   logic [19:0]  lnk_addr;
   logic         lnk_grant = 1'b0, lnk_ready = 1'b0, lnk_done = 1'b0;
   logic [3:0]   lnk_reply;
   logic [4:0]   lnk_rcount = '0;
   localparam logic [127:0] RPAT = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
   logic [127:0] lnk_rdata;
   assign lnk_rdata = RPAT;

   auxreq_seq #(.GRANT_WAIT(GW), .POLL_GAP(PG), .CLR_TMO(CT), .SETTLE_CYC(SC),
                .TAIL_CYC(TC), .MAX_ATTEMPTS(MA)) i_auxreq_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .done_pulse(done_pulse), .done_code(done_code), .done_reply(done_reply),
      .done_rdata(done_rdata), .lnk_acq(lnk_acq), .lnk_grant(lnk_grant),
      .lnk_ready(lnk_ready), .lnk_wload(lnk_wload), .lnk_wdata(lnk_wdata),
      .lnk_cmd(lnk_cmd), .lnk_addr(lnk_addr), .lnk_len(lnk_len), .lnk_rst(lnk_rst),
      .lnk_start(lnk_start), .lnk_done(lnk_done), .lnk_reply(lnk_reply),
      .lnk_rcount(lnk_rcount), .lnk_rdata(lnk_rdata)
   );

   // transceiver model configuration (written only by the test tasks)
   int         cfg_grant = 0;     // 0 follow claim, 1 never, 2 stuck on
   logic       cfg_ready = 1'b1;
   logic       cfg_stall = 1'b0;
   int         cfg_defers = 0;
   logic [3:0] cfg_reply = 4'h0;
   logic [4:0] cfg_rcount = 5'd0;
   int         base_rst = 0, base_wl = 0;

   int rst_total = 0, wl_total = 0, start_cyc = 0, rel_cnt = 0;

   always @(posedge clk) begin
      lnk_grant  <= (cfg_grant == 0) ? lnk_acq : (cfg_grant == 2);
      lnk_ready  <= cfg_ready;
      lnk_rcount <= cfg_rcount;
      if (lnk_rst)   rst_total <= rst_total + 1;
      if (lnk_wload) wl_total  <= wl_total + 1;
      if (lnk_acq)   rel_cnt <= 0; else rel_cnt <= rel_cnt + 1;
      if (lnk_start && !lnk_done) begin
         start_cyc <= start_cyc + 1;
         if (start_cyc == 2 && !cfg_stall) lnk_done <= 1'b1;
      end else begin
         start_cyc <= 0;
         lnk_done  <= 1'b0;
      end
   end
   assign lnk_reply = ((rst_total - base_rst) <= cfg_defers) ? 4'b0010 : cfg_reply;

   int checks = 0, errors = 0;
   logic [1:0]   got_code;
   logic [3:0]   got_reply;
   logic [127:0] got_rdata;
   int           got_gap;
   logic         got_busy_ready;

   task automatic check(input string req, input string what, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [127:0] keep_bytes(input logic [127:0] d, input int last);
      logic [127:0] r = '0;
      for (int b = 0; b <= last; b++) r[8*b +: 8] = d[8*b +: 8];
      return r;
   endfunction

   task automatic run(input logic [3:0] cmd, input logic [19:0] addr,
                      input logic [3:0] len, input logic [127:0] wd);
      @(negedge clk);
      base_rst = rst_total; base_wl = wl_total;
      req_cmd = cmd; req_addr = addr; req_len = len; req_wdata = wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      got_busy_ready = req_ready;
      for (int n = 0; n < 4000; n++) begin
         if (done_pulse) break;
         @(negedge clk);
      end
      got_code = done_code; got_reply = done_reply; got_rdata = done_rdata; got_gap = rel_cnt;
      check("R1", "done seen", {127'd0, done_pulse}, 128'd1);
      @(negedge clk);
      check("R1", "done single", {127'd0, done_pulse}, 128'd0);
   endtask

   task automatic t_write_ok;
      cfg_grant = 0; cfg_ready = 1; cfg_stall = 0; cfg_defers = 0; cfg_reply = 4'h0;
      run(4'h8, 20'h00101, 4'd3, 128'hAAAA_BBBB_CCCC_DDDD_1111_2222_3344_5566);
      check("R1", "ready low while busy", {127'd0, got_busy_ready}, 128'd0);
      check("R10", "write status", got_code, 0);
      check("R4", "one payload load", wl_total - base_wl, 1);
      check("R5", "one attempt", rst_total - base_rst, 1);
      check("R4", "length field", lnk_len, 3);
      check("R4", "command", lnk_cmd, 4'h8);
      check("R4", "masked payload", lnk_wdata, 128'h0000_0000_0000_0000_0000_0000_3344_5566);
      check("R9", "claim dropped", lnk_acq, 0);
      check("R10", "tail delay", {127'd0, got_gap >= GW + TC}, 128'd1);
   endtask

   task automatic t_write_nack;
      cfg_defers = 0; cfg_reply = 4'h1;
      run(4'h8, 20'h00200, 4'd0, 128'h55);
      check("R10", "refusal status", got_code, 0);
      check("R10", "refusal reply", got_reply, 4'h1);
      check("R7", "no retry on refusal", rst_total - base_rst, 1);
   endtask

   task automatic t_read_full;
      cfg_reply = 4'h4; cfg_rcount = 5'd16;
      run(4'h9, 20'h00000, 4'd15, '0);
      check("R8", "full read status", got_code, 0);
      check("R8", "full read data", got_rdata, RPAT);
      check("R10", "read reply", got_reply, 4'h4);
      check("R4", "no load on read", wl_total - base_wl, 0);
   endtask

   task automatic t_read_short;
      cfg_reply = 4'h0; cfg_rcount = 5'd5;
      run(4'h9, 20'h00010, 4'd4, '0);
      check("R8", "short read status", got_code, 0);
      check("R8", "short read masked", got_rdata, keep_bytes(RPAT, 4));
   endtask

   task automatic t_read_mismatch;
      cfg_rcount = 5'd3;
      run(4'h9, 20'h00010, 4'd4, '0);
      check("R8", "count mismatch", got_code, 3);
      check("R10", "no reply on error", got_reply, 0);
   endtask

   task automatic t_defer_some;
      cfg_defers = 3; cfg_reply = 4'h0;
      run(4'h8, 20'h00300, 4'd1, 128'h1234);
      check("R7", "deferred then ok", got_code, 0);
      check("R7", "attempts after 3 deferrals", rst_total - base_rst, 4);
   endtask

   task automatic t_defer_forever;
      cfg_defers = 1000;
      run(4'h8, 20'h00300, 4'd1, 128'h1234);
      check("R7", "retry exhausted", got_code, 3);
      check("R7", "attempt count", rst_total - base_rst, MA);
      cfg_defers = 0;
   endtask

   task automatic t_no_grant;
      cfg_grant = 1;
      run(4'h8, 20'h00400, 4'd0, 128'h1);
      check("R2", "no grant status", got_code, 1);
      check("R2", "no attempt", rst_total - base_rst, 0);
      cfg_grant = 0;
   endtask

   task automatic t_never_ready;
      cfg_ready = 0;
      run(4'h9, 20'h00400, 4'd0, '0);
      check("R3", "never ready status", got_code, 2);
      check("R3", "no attempt", rst_total - base_rst, 0);
      cfg_ready = 1;
   endtask

   task automatic t_start_stall;
      cfg_stall = 1;
      run(4'h8, 20'h00500, 4'd0, 128'h1);
      check("R6", "start stall status", got_code, 2);
      check("R6", "single attempt", rst_total - base_rst, 1);
      cfg_stall = 0;
   endtask

   task automatic t_grant_stuck;
      cfg_grant = 2; cfg_reply = 4'h0;
      run(4'h8, 20'h00600, 4'd0, 128'h1);
      check("R9", "grant kept status", got_code, 1);
      check("R9", "reply cleared", got_reply, 0);
      cfg_grant = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset ready", req_ready, 1);
      check("R1", "reset claim", lnk_acq, 0);
      check("R5", "reset start", lnk_start, 0);
      t_write_ok();
      t_write_nack();
      t_read_full();
      t_read_short();
      t_read_mismatch();
      t_defer_some();
      t_defer_forever();
      t_no_grant();
      t_never_ready();
      t_start_stall();
      t_grant_stuck();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule